// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block decides which oscillator clocks the chip and steps the chip safely from the internal oscillator onto an external resonator. After reset the internal source is active and the CPU runs. Software writes a small configuration register. Setting the external-enable field stops the chip clocks, turns the internal oscillator off and starts the external one. The block then waits for the external source to report that it is stable, holds the CPU for a programmable resume delay, and only then lets it run.

Once the block is in external mode it stays there. Clearing the enable field has no effect until the chip goes through a suspend and a wake. At the wake the enable field is sampled to choose the source again. The block also controls the output oscillator pin. While the internal source is active, it returns the input oscillator pin as a general-purpose input bit. Both delays are counted in reference-clock cycles and are set by parameters.

Top module: `clk_src_sequencer`

## Requirements
- R1: After reset, seqState reads 0 (internal running), cpuRun is 1, selExt is 0, intOscEn is 1, extOscEn is 0 and regRdData reads 0.
- R2: A register write stores bit 0 (external enable), bit 1 (output-pin clock off), bit 2 (precision tuning enable, shown on precTuneEn), bit 3 (low-voltage reset off, shown on lvrDisable) and bit 7 (long resume delay). Bits 4 to 6 are not stored and read back 0.
- R3: In state 0 with no suspendReq, a write with bit 0 set moves the block to state 1 (halted, waiting for stable) on the next cycle. In that state cpuRun=0, chipClkEn=0, selExt=1, intOscEn=0 and extOscEn=1.
- R4: State 1 persists while extStable is low. A cycle with extStable high moves the block to state 2 (resume delay).
- R5: The block stays in state 2 for exactly SHORT_DLY cycles when register bit 7 was 0 at the stable event, and for exactly LONG_DLY cycles when it was 1. It then enters state 3 (external running) with cpuRun=1 and chipClkEn=1.
- R6: In state 3, a write that clears bit 0 leaves the state at 3 and selExt at 1.
- R7: In internal mode xoutOe=1. xoutLevel is 1 when bit 1 is set, and follows intClk when bit 1 is clear. In external mode xoutOe=0 and xoutLevel=0 whatever bit 1 holds.
- R8: In internal mode gpioBit follows xinPin. In external mode gpioBit is 0.
- R9: suspendReq in state 0 or 3 moves the block to state 4 (suspended), where cpuRun=0. A wakeReq while bit 0 is clear returns the block to state 0 on the internal source with cpuRun=1.
- R10: A wakeReq while bit 0 is set moves the block to state 1. The full halt, stable-wait and resume-delay sequence then runs again before cpuRun returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Configuration write strobe |
| regWrData | input | 8 | Configuration write data |
| regRdData | output | 8 | Configuration read-back |
| seqState | output | 3 | Sequencer state: 0 internal run, 1 halt/wait stable, 2 resume delay, 3 external run, 4 suspended |
| extStable | input | 1 | External source reports stable |
| suspendReq | input | 1 | Request to enter suspend |
| wakeReq | input | 1 | Wake from suspend |
| intClk | input | 1 | Internal oscillator level, for the output pin |
| xinPin | input | 1 | Input oscillator pin level |
| cpuRun | output | 1 | CPU released to run |
| selExt | output | 1 | Clock select: 1 external, 0 internal |
| chipClkEn | output | 1 | Chip clock enable |
| intOscEn | output | 1 | Internal oscillator enable |
| extOscEn | output | 1 | External oscillator enable |
| xoutOe | output | 1 | Output pin driven by this block |
| xoutLevel | output | 1 | Level driven on the output pin |
| gpioBit | output | 1 | Input pin read as a general-purpose bit |
| precTuneEn | output | 1 | Precision tuning enable field |
| lvrDisable | output | 1 | Low-voltage reset disable field |

## Verification
The hardest case to reach is the second external sequence that a wake starts. To get there, the block must first finish one full switch into external mode and then enter suspend. The wake must then arrive while bit 0 is still set. The stimulus does this by switching with the long delay selected, suspending and waking. It then counts the cycles of the resume delay a second time. The same run also cleared bit 0 while in external mode and then woke into internal mode. This shows that the sample taken at the wake is the only path back to the internal source.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;
  typedef enum logic [2:0] {
    ST_INT_RUN   = 3'd0,
    ST_HALT_WAIT = 3'd1,
    ST_RESUME    = 3'd2,
    ST_EXT_RUN   = 3'd3,
    ST_SUSPENDED = 3'd4
  } seqState_e;

  typedef struct packed {
    logic cfgWr;
    logic ctrLoad;
    logic setExt;
    logic clrExt;
  } seqStrobe_t;

  localparam int CFG_EXT_EN   = 0;
  localparam int CFG_XOUT_OFF = 1;
  localparam int CFG_TUNE     = 2;
  localparam int CFG_LVR_OFF  = 3;
  localparam int CFG_LONG_DLY = 7;
  localparam logic [7:0] CFG_MASK = 8'h8F;
endpackage

// File: rtl/clk_seq_datapath.sv
module clk_seq_datapath
  import clk_seq_pkg::*;
#(
  parameter int SHORT_DLY = 768,
  parameter int LONG_DLY  = 24000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic [7:0] wrData,
  input  logic       intClk,
  input  logic       xinPin,
  output logic [7:0] cfgOut,
  output logic       extMode,
  output logic       ctrZero,
  output logic       xoutOe,
  output logic       xoutLevel,
  output logic       gpioBit
);
  localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_DLY - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_DLY - 1);

  logic [7:0]       cfgReg;
  logic [CNT_W-1:0] ctr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (strb.cfgWr) cfgReg <= wrData & CFG_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extMode <= 1'b0;
    else if (strb.setExt) extMode <= 1'b1;
    else if (strb.clrExt) extMode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctr <= '0;
    else if (strb.ctrLoad) ctr <= cfgReg[CFG_LONG_DLY] ? LONG_LD : SHORT_LD;
    else if (ctr != '0) ctr <= ctr - 1'b1;
  end

  assign ctrZero = (ctr == '0);
  assign cfgOut  = cfgReg;

  always_comb begin
    xoutOe    = !extMode;
    xoutLevel = 1'b0;
    gpioBit   = 1'b0;
    if (!extMode) begin
      xoutLevel = cfgReg[CFG_XOUT_OFF] ? 1'b1 : intClk;
      gpioBit   = xinPin;
    end
  end
endmodule

// File: rtl/clk_seq_ctrl.sv
module clk_seq_ctrl
  import clk_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       wrExtBit,
  input  logic       cfgExtBit,
  input  logic       extStable,
  input  logic       suspendReq,
  input  logic       wakeReq,
  input  logic       ctrZero,
  output seqState_e  state,
  output seqStrobe_t strb
);
  seqState_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INT_RUN;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '0;
    strb.cfgWr = regWrEn;
    unique case (state)
      ST_INT_RUN: begin
        if (suspendReq) nextState = ST_SUSPENDED;
        else if (regWrEn && wrExtBit) begin
          nextState   = ST_HALT_WAIT;
          strb.setExt = 1'b1;
        end
      end
      ST_HALT_WAIT: begin
        if (extStable) begin
          nextState    = ST_RESUME;
          strb.ctrLoad = 1'b1;
        end
      end
      ST_RESUME: begin
        if (ctrZero) nextState = ST_EXT_RUN;
      end
      ST_EXT_RUN: begin
        if (suspendReq) nextState = ST_SUSPENDED;
      end
      ST_SUSPENDED: begin
        if (wakeReq) begin
          if (cfgExtBit) begin
            nextState   = ST_HALT_WAIT;
            strb.setExt = 1'b1;
          end else begin
            nextState   = ST_INT_RUN;
            strb.clrExt = 1'b1;
          end
        end
      end
      default: nextState = ST_INT_RUN;
    endcase
  end
endmodule

// File: rtl/clk_src_sequencer.sv
module clk_src_sequencer
  import clk_seq_pkg::*;
#(
  parameter int SHORT_DLY = 768,
  parameter int LONG_DLY  = 24000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic [2:0] seqState,
  input  logic       extStable,
  input  logic       suspendReq,
  input  logic       wakeReq,
  input  logic       intClk,
  input  logic       xinPin,
  output logic       cpuRun,
  output logic       selExt,
  output logic       chipClkEn,
  output logic       intOscEn,
  output logic       extOscEn,
  output logic       xoutOe,
  output logic       xoutLevel,
  output logic       gpioBit,
  output logic       precTuneEn,
  output logic       lvrDisable
);
  seqState_e  state;
  seqStrobe_t strb;
  logic [7:0] cfg;
  logic       extMode;
  logic       ctrZero;

  clk_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .wrExtBit(regWrData[CFG_EXT_EN]), .cfgExtBit(cfg[CFG_EXT_EN]),
    .extStable(extStable), .suspendReq(suspendReq), .wakeReq(wakeReq),
    .ctrZero(ctrZero), .state(state), .strb(strb)
  );

  clk_seq_datapath #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .intClk(intClk), .xinPin(xinPin), .cfgOut(cfg), .extMode(extMode),
    .ctrZero(ctrZero), .xoutOe(xoutOe), .xoutLevel(xoutLevel), .gpioBit(gpioBit)
  );

  assign regRdData  = cfg;
  assign seqState   = state;
  assign cpuRun     = (state == ST_INT_RUN) || (state == ST_EXT_RUN);
  assign chipClkEn  = (state != ST_HALT_WAIT) && (state != ST_SUSPENDED);
  assign selExt     = extMode;
  assign intOscEn   = !extMode;
  assign extOscEn   = extMode;
  assign precTuneEn = cfg[CFG_TUNE];
  assign lvrDisable = cfg[CFG_LVR_OFF];
endmodule

// File: rtl/clk_seq_checker.sv
module clk_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic [2:0] seqState,
  input logic       extStable,
  input logic       suspendReq,
  input logic       wakeReq,
  input logic       cpuRun,
  input logic       selExt,
  input logic       xoutOe,
  input logic       gpioBit
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & 8'h70) == 8'h00); // R2
  AST_WRITE_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd0 && regWrEn && regWrData[0] && !suspendReq) |=> (!cpuRun && selExt)); // R3
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd1 && !extStable) |=> seqState == 3'd1); // R4
  AST_RELEASE_AFTER_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cpuRun) && selExt) |-> $past(seqState) == 3'd2); // R5
  AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd3 && !suspendReq) |=> (seqState == 3'd3 && selExt)); // R6
  AST_XOUT_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    selExt |-> !xoutOe); // R7
  AST_GPIO_EXT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    selExt |-> !gpioBit); // R8
  AST_WAKE_INTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd4 && wakeReq && !regRdData[0]) |=> (cpuRun && !selExt)); // R9
  AST_WAKE_EXTERNAL: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == 3'd4 && wakeReq && regRdData[0]) |=> (seqState == 3'd1 && !cpuRun)); // R10
endmodule

bind clk_src_sequencer clk_seq_checker u_chk (.*);

// File: tb/tb_clk_src_sequencer.sv
module tb_clk_src_sequencer;
  localparam int SHORT = 12;
  localparam int LONG  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic extStable = 1'b0, suspendReq = 1'b0, wakeReq = 1'b0;
  logic intClk = 1'b0, xinPin = 1'b0;
  logic [7:0] regRdData;
  logic [2:0] seqState;
  logic cpuRun, selExt, chipClkEn, intOscEn, extOscEn;
  logic xoutOe, xoutLevel, gpioBit, precTuneEn, lvrDisable;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  clk_src_sequencer #(.SHORT_DLY(SHORT), .LONG_DLY(LONG)) dut (.*);

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d; tick(); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic t_reset();
    chk("R1 state", seqState, 0); chk("R1 cpuRun", cpuRun, 1);
    chk("R1 selExt", selExt, 0); chk("R1 intOscEn", intOscEn, 1);
    chk("R1 extOscEn", extOscEn, 0); chk("R1 cfg", regRdData, 0);
  endtask

  task automatic t_fields();
    wr(8'hFE);
    chk("R2 readback", regRdData, 8'h8E);
    chk("R2 precTuneEn", precTuneEn, 1); chk("R2 lvrDisable", lvrDisable, 1);
    chk("R2 still internal", seqState, 0);
    wr(8'h00);
    chk("R2 cleared", regRdData, 0);
  endtask

  task automatic t_pins_int();
    intClk = 1'b1; xinPin = 1'b1; #1;
    chk("R7 oe int", xoutOe, 1); chk("R7 clk out hi", xoutLevel, 1);
    chk("R8 gpio hi", gpioBit, 1);
    intClk = 1'b0; xinPin = 1'b0; #1;
    chk("R7 clk out lo", xoutLevel, 0); chk("R8 gpio lo", gpioBit, 0);
    wr(8'h02); #1;
    chk("R7 forced high", xoutLevel, 1);
    wr(8'h00);
  endtask

  task automatic run_switch(input int expDly, input string tag);
    chk({tag, " halted state"}, seqState, 1); chk({tag, " cpu held"}, cpuRun, 0);
    chk({tag, " clocks off"}, chipClkEn, 0); chk({tag, " selExt"}, selExt, 1);
    chk({tag, " intOscEn"}, intOscEn, 0); chk({tag, " extOscEn"}, extOscEn, 1);
    for (int i = 0; i < 5; i++) tick();
    chk("R4 waits for stable", seqState, 1);
    extStable = 1'b1; tick(); extStable = 1'b0;
    chk("R4 resume state", seqState, 2);
    begin
      int n = 0;
      while (seqState == 3'd2 && n < LONG + 10) begin tick(); n++; end
      chk({tag, " R5 delay cycles"}, n, expDly);
    end
    chk("R5 ext run", seqState, 3); chk("R5 cpuRun", cpuRun, 1);
    chk("R5 chipClkEn", chipClkEn, 1);
  endtask

  task automatic t_switch_short();
    wr(8'h01);
    run_switch(SHORT, "R3");
  endtask

  task automatic t_ext_sticky();
    xinPin = 1'b1; intClk = 1'b1;
    wr(8'h02); #1;
    chk("R6 stays ext", seqState, 3); chk("R6 selExt", selExt, 1);
    chk("R7 oe ext", xoutOe, 0); chk("R7 level ext", xoutLevel, 0);
    chk("R8 gpio ext", gpioBit, 0);
    xinPin = 1'b0; intClk = 1'b0;
  endtask

  task automatic t_wake_int();
    suspendReq = 1'b1; tick(); suspendReq = 1'b0;
    chk("R9 suspended", seqState, 4); chk("R9 cpu off", cpuRun, 0);
    tick(); chk("R9 waits for wake", seqState, 4);
    wakeReq = 1'b1; tick(); wakeReq = 1'b0;
    chk("R9 internal again", seqState, 0); chk("R9 selExt", selExt, 0);
    chk("R9 cpuRun", cpuRun, 1);
  endtask

  task automatic t_wake_ext();
    wr(8'h81);
    run_switch(LONG, "R3 long");
    suspendReq = 1'b1; tick(); suspendReq = 1'b0;
    chk("R10 suspended", seqState, 4);
    wakeReq = 1'b1; tick(); wakeReq = 1'b0;
    run_switch(LONG, "R10");
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();
    t_reset();
    t_fields();
    t_pins_int();
    t_switch_short();
    t_ext_sticky();
    t_wake_int();
    t_wake_ext();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule